// File: doc/BRIEF.md
# Credit-gated shared-buffer queue manager

This block keeps the cell queues of a small switch output stage. Every cell lives in one common pool of `NSLOT` slots (256 by default), addressed by a cell index that the sender supplies with the cell. Each cell carries a flow group and a destination output. Every flow group owns a credit counter. A cell whose group holds a credit when it arrives spends that credit and joins the ready FIFO of its output. A cell whose group has no credit is parked in that group's waiting FIFO. When a credit arrives for a group that has parked cells, the oldest parked cell moves to the ready FIFO of its own output and the credit is spent. If no cells are parked, the counter goes up instead, saturating at `CMAX`.

All queues are linked lists threaded through one next-pointer store that is indexed by cell index, so a move between lists costs one pointer write. In each clock the block accepts one arrival, one departure request and one credit. Their effects on state are ordered as departure, then credit, then arrival. The arrival port is valid/ready: `arr_ready` falls only when every slot is occupied, and a cell is taken on a cycle where both are high. Departure requests and credits are always accepted. The departure response comes one cycle after its request and has no back-pressure, so its consumer must take it.

Top module: `shq_credit_qm`

## Requirements
- R1: After reset, or a reset in mid-run, `used_slots` is 0, `ready_nonempty` is 0, `arr_ready` is 1, `rsp_valid` is 0, every credit counter is 0, and no cell can be departed.
- R2: An accepted arrival whose flow group has a credit enters the ready FIFO of `arr_port` and spends exactly one credit.
- R3: An accepted arrival whose flow group has no credit enters that group's waiting FIFO, and departures on its output miss until a credit releases it.
- R4: A credit for a group with parked cells moves the oldest parked cell to the ready FIFO of that cell's output and leaves the counter unchanged. A credit for a group with no parked cells increments the counter.
- R5: Credit counters saturate at `CMAX` (7 by default), so extra credits are lost.
- R6: A request with `dep_req`=1 on `dep_port` gives `rsp_valid`=1 on the next cycle. On a hit, `rsp_hit`=1 and `rsp_cell` and `rsp_fg` give the oldest ready cell of that output, which is then removed.
- R7: A departure request on an empty ready FIFO gives `rsp_valid`=1 with `rsp_hit`=0 and changes no occupancy or queue state.
- R8: `used_slots` counts the occupied slots. When it equals `NSLOT`, `arr_ready` is 0 and an offered arrival is not taken. One departure reopens the port.
- R9: Cells of one flow group bound for one output leave in arrival order, whether or not they waited.
- R10: Within one cycle, a departure sees the state from before that cycle. A credit acts before an arrival of the same cycle, so a credit and an arrival for a group with no credit and no parked cells place that cell in a ready FIFO.
- R11: An arrival, a departure and a credit can all be taken on every cycle with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Arrival offered |
| arr_ready | output | 1 | Arrival can be taken (pool not full) |
| arr_fg | input | FW | Flow group of arriving cell |
| arr_port | input | OW | Destination output of arriving cell |
| arr_cell | input | IW | Slot index of arriving cell (must be free) |
| dep_req | input | 1 | Departure request |
| dep_port | input | OW | Output whose ready FIFO is popped |
| rsp_valid | output | 1 | Response to previous cycle's request |
| rsp_hit | output | 1 | A cell was popped |
| rsp_cell | output | IW | Slot index of popped cell |
| rsp_fg | output | FW | Flow group of popped cell |
| crd_valid | input | 1 | Credit arrives |
| crd_fg | input | FW | Flow group receiving the credit |
| used_slots | output | CW | Occupied slot count |
| ready_nonempty | output | NOUT | Per-output ready FIFO non-empty flags |

## Verification
A broken link in the pointer store shows up at the next departure from the affected FIFO. The wrong `rsp_cell` appears one cycle after the request, or the FIFO runs dry early and returns a miss while `used_slots` is still non-zero. A counter that drifts, or a cell that goes to the wrong list, shows up later: a departure hits when it should miss, or misses when it should hit, on the first request after the next credit or arrival for that group. The bench therefore pairs every credit and arrival pattern with a departure one or two cycles later, and compares `used_slots` after every cycle.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int unsigned QM_SLOTS  = 256;
  localparam int unsigned QM_OUTS   = 4;
  localparam int unsigned QM_GROUPS = 8;
  localparam int unsigned QM_CMAX   = 7;

  // order in which one cycle's events act on queue state
  typedef enum logic [1:0] {
    STEP_DEPART = 2'd0,
    STEP_CREDIT = 2'd1,
    STEP_ARRIVE = 2'd2
  } qm_step_e;
endpackage

// File: rtl/qm_node_store.sv
module qm_node_store #(
  parameter int unsigned NSLOT = 256,
  parameter int unsigned IW    = 8,
  parameter int unsigned FW    = 3,
  parameter int unsigned OW    = 2
) (
  input  logic          clk,
  input  logic          node_we,
  input  logic [IW-1:0] node_addr,
  input  logic [FW-1:0] node_fg,
  input  logic [OW-1:0] node_port,
  input  logic          lw0_en,
  input  logic [IW-1:0] lw0_addr,
  input  logic [IW-1:0] lw0_data,
  input  logic          lw1_en,
  input  logic [IW-1:0] lw1_addr,
  input  logic [IW-1:0] lw1_data,
  input  logic [IW-1:0] rd_a_addr,
  output logic [IW-1:0] next_a,
  output logic [FW-1:0] fg_a,
  input  logic [IW-1:0] rd_b_addr,
  output logic [IW-1:0] next_b,
  output logic [OW-1:0] port_b
);
  logic [IW-1:0] link_mem [NSLOT];
  logic [FW-1:0] fg_mem   [NSLOT];
  logic [OW-1:0] port_mem [NSLOT];

  // two link writes per cycle; the controller never aims both at one slot
  always_ff @(posedge clk) begin
    if (lw0_en) link_mem[lw0_addr] <= lw0_data;
    if (lw1_en) link_mem[lw1_addr] <= lw1_data;
  end

  always_ff @(posedge clk) begin
    if (node_we) begin
      fg_mem[node_addr]   <= node_fg;
      port_mem[node_addr] <= node_port;
    end
  end

  assign next_a = link_mem[rd_a_addr];
  assign fg_a   = fg_mem[rd_a_addr];
  assign next_b = link_mem[rd_b_addr];
  assign port_b = port_mem[rd_b_addr];
endmodule

// File: rtl/qm_credit_bank.sv
module qm_credit_bank #(
  parameter int unsigned NFG  = 8,
  parameter int unsigned FW   = 3,
  parameter int unsigned CMAX = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           crd_inc,
  input  logic [FW-1:0]  crd_fg,
  input  logic           arr_take,
  input  logic [FW-1:0]  arr_fg,
  output logic           arr_has_credit,
  output logic [NFG-1:0] crd_nz
);
  localparam int unsigned KW = $clog2(CMAX + 1);
  localparam logic [KW-1:0] KMAX = KW'(CMAX);

  logic [NFG*KW-1:0] cnt_flat;
  logic [KW-1:0]     cnt_arr;

  for (genvar g = 0; g < NFG; g++) begin : g_grp
    logic          inc_g, dec_g;
    logic [KW-1:0] cnt_q, after_crd;
    assign inc_g = crd_inc && (crd_fg == FW'(g));
    assign dec_g = arr_take && (arr_fg == FW'(g));
    // credit first, saturating; then the arrival spends one
    always_comb begin
      after_crd = cnt_q;
      if (inc_g && cnt_q != KMAX) after_crd = cnt_q + KW'(1);
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (dec_g) cnt_q <= after_crd - KW'(1);
      else            cnt_q <= after_crd;
    end
    assign cnt_flat[g*KW +: KW] = cnt_q;
    assign crd_nz[g] = (cnt_q != '0);
  end

  assign cnt_arr = cnt_flat[arr_fg*KW +: KW];
  assign arr_has_credit = (cnt_arr != '0) || (crd_inc && crd_fg == arr_fg);
endmodule

// File: rtl/shq_credit_qm.sv
module shq_credit_qm
  import qm_pkg::*;
#(
  parameter int unsigned NSLOT = QM_SLOTS,
  parameter int unsigned NOUT  = QM_OUTS,
  parameter int unsigned NFG   = QM_GROUPS,
  parameter int unsigned CMAX  = QM_CMAX,
  localparam int unsigned IW = $clog2(NSLOT),
  localparam int unsigned OW = $clog2(NOUT),
  localparam int unsigned FW = $clog2(NFG),
  localparam int unsigned CW = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arr_valid,
  output logic            arr_ready,
  input  logic [FW-1:0]   arr_fg,
  input  logic [OW-1:0]   arr_port,
  input  logic [IW-1:0]   arr_cell,
  input  logic            dep_req,
  input  logic [OW-1:0]   dep_port,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [IW-1:0]   rsp_cell,
  output logic [FW-1:0]   rsp_fg,
  input  logic            crd_valid,
  input  logic [FW-1:0]   crd_fg,
  output logic [CW-1:0]   used_slots,
  output logic [NOUT-1:0] ready_nonempty
);
  // ready FIFOs per output, waiting FIFOs per flow group
  logic [IW-1:0]   rq_head [NOUT], rq_tail [NOUT];
  logic [IW-1:0]   n_rqh   [NOUT], n_rqt   [NOUT];
  logic [NOUT-1:0] rq_ne, n_rqne;
  logic [IW-1:0]   wq_head [NFG],  wq_tail [NFG];
  logic [IW-1:0]   n_wqh   [NFG],  n_wqt   [NFG];
  logic [NFG-1:0]  wq_ne, n_wqne;
  logic [CW-1:0]   used_q;

  logic          lw0_en, lw1_en;
  logic [IW-1:0] lw0_addr, lw0_data, lw1_addr, lw1_data;
  logic [IW-1:0] rd_a_addr, next_a, rd_b_addr, next_b;
  logic [FW-1:0] fg_a;
  logic [OW-1:0] port_b;

  logic           arr_go, arr_has_credit, dep_hit, crd_move, crd_inc;
  logic [NFG-1:0] crd_nz;
  qm_step_e       step_dbg;

  assign arr_ready = (used_q < CW'(NSLOT));
  assign arr_go    = arr_valid && arr_ready;
  assign dep_hit   = dep_req && rq_ne[dep_port];
  assign crd_move  = crd_valid && wq_ne[crd_fg];
  assign crd_inc   = crd_valid && !wq_ne[crd_fg];
  assign rd_a_addr = rq_head[dep_port];
  assign rd_b_addr = wq_head[crd_fg];

  qm_node_store #(.NSLOT(NSLOT), .IW(IW), .FW(FW), .OW(OW)) u_nodes (
    .clk       (clk),
    .node_we   (arr_go),
    .node_addr (arr_cell),
    .node_fg   (arr_fg),
    .node_port (arr_port),
    .lw0_en    (lw0_en),
    .lw0_addr  (lw0_addr),
    .lw0_data  (lw0_data),
    .lw1_en    (lw1_en),
    .lw1_addr  (lw1_addr),
    .lw1_data  (lw1_data),
    .rd_a_addr (rd_a_addr),
    .next_a    (next_a),
    .fg_a      (fg_a),
    .rd_b_addr (rd_b_addr),
    .next_b    (next_b),
    .port_b    (port_b)
  );

  qm_credit_bank #(.NFG(NFG), .FW(FW), .CMAX(CMAX)) u_credits (
    .clk            (clk),
    .rst_n          (rst_n),
    .crd_inc        (crd_inc),
    .crd_fg         (crd_fg),
    .arr_take       (arr_go && arr_has_credit),
    .arr_fg         (arr_fg),
    .arr_has_credit (arr_has_credit),
    .crd_nz         (crd_nz)
  );

  // next queue state: the three steps applied in order on running copies
  always_comb begin
    n_rqh  = rq_head;
    n_rqt  = rq_tail;
    n_rqne = rq_ne;
    n_wqh  = wq_head;
    n_wqt  = wq_tail;
    n_wqne = wq_ne;
    lw0_en = 1'b0; lw0_addr = '0; lw0_data = '0;
    lw1_en = 1'b0; lw1_addr = '0; lw1_data = '0;
    step_dbg = STEP_DEPART;

    // departure: pop the ready head of dep_port
    if (dep_hit) begin
      if (rq_head[dep_port] == rq_tail[dep_port]) n_rqne[dep_port] = 1'b0;
      else                                        n_rqh[dep_port]  = next_a;
    end

    // credit: release the oldest parked cell of crd_fg
    if (crd_move) begin
      step_dbg = STEP_CREDIT;
      if (wq_head[crd_fg] == wq_tail[crd_fg]) n_wqne[crd_fg] = 1'b0;
      else                                    n_wqh[crd_fg]  = next_b;
      if (n_rqne[port_b]) begin
        lw0_en   = 1'b1;
        lw0_addr = n_rqt[port_b];
        lw0_data = rd_b_addr;
      end else begin
        n_rqh[port_b] = rd_b_addr;
      end
      n_rqt[port_b]  = rd_b_addr;
      n_rqne[port_b] = 1'b1;
    end

    // arrival: append to a ready or a waiting FIFO
    if (arr_go) begin
      step_dbg = STEP_ARRIVE;
      if (arr_has_credit) begin
        if (n_rqne[arr_port]) begin
          lw1_en   = 1'b1;
          lw1_addr = n_rqt[arr_port];
          lw1_data = arr_cell;
        end else begin
          n_rqh[arr_port] = arr_cell;
        end
        n_rqt[arr_port]  = arr_cell;
        n_rqne[arr_port] = 1'b1;
      end else begin
        if (n_wqne[arr_fg]) begin
          lw1_en   = 1'b1;
          lw1_addr = n_wqt[arr_fg];
          lw1_data = arr_cell;
        end else begin
          n_wqh[arr_fg] = arr_cell;
        end
        n_wqt[arr_fg]  = arr_cell;
        n_wqne[arr_fg] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NOUT; i++) begin
        rq_head[i] <= '0;
        rq_tail[i] <= '0;
      end
      for (int j = 0; j < NFG; j++) begin
        wq_head[j] <= '0;
        wq_tail[j] <= '0;
      end
      rq_ne  <= '0;
      wq_ne  <= '0;
      used_q <= '0;
    end else begin
      rq_head <= n_rqh;
      rq_tail <= n_rqt;
      rq_ne   <= n_rqne;
      wq_head <= n_wqh;
      wq_tail <= n_wqt;
      wq_ne   <= n_wqne;
      used_q  <= used_q + CW'(arr_go) - CW'(dep_hit);
    end
  end

  // registered departure response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_cell  <= '0;
      rsp_fg    <= '0;
    end else begin
      rsp_valid <= dep_req;
      rsp_hit   <= dep_hit;
      rsp_cell  <= dep_hit ? rd_a_addr : '0;
      rsp_fg    <= dep_hit ? fg_a : '0;
    end
  end

  assign used_slots     = used_q;
  assign ready_nonempty = rq_ne;
endmodule

// File: rtl/shq_credit_qm_chk.sv
module shq_credit_qm_chk #(
  parameter int unsigned NSLOT = 256,
  parameter int unsigned NOUT  = 4,
  parameter int unsigned NFG   = 8,
  localparam int unsigned OW = $clog2(NOUT),
  localparam int unsigned CW = $clog2(NSLOT + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arr_valid,
  input logic            arr_ready,
  input logic            dep_req,
  input logic [OW-1:0]   dep_port,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [CW-1:0]   used_slots,
  input logic [NOUT-1:0] ready_nonempty,
  input logic [NFG-1:0]  wq_ne,
  input logic [NFG-1:0]  crd_nz
);
  assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dep_req |=> rsp_valid);

  assert_no_idle_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dep_req |=> !rsp_valid);

  assert_hit_is_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_empty_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_req && !ready_nonempty[dep_port] && !(arr_valid && arr_ready))
      |=> (rsp_valid && !rsp_hit && $stable(used_slots)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    used_slots <= CW'(NSLOT));

  assert_used_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (used_slots == $past(used_slots) + CW'($past(arr_valid && arr_ready))
                             - CW'(rsp_valid && rsp_hit)));

  // a group never both holds credit and has parked cells
  assert_credit_xor_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_ne & crd_nz) == '0);
endmodule

bind shq_credit_qm shq_credit_qm_chk #(.NSLOT(NSLOT), .NOUT(NOUT), .NFG(NFG)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .arr_valid      (arr_valid),
  .arr_ready      (arr_ready),
  .dep_req        (dep_req),
  .dep_port       (dep_port),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .used_slots     (used_slots),
  .ready_nonempty (ready_nonempty),
  .wq_ne          (wq_ne),
  .crd_nz         (crd_nz)
);

// File: tb/shq_credit_qm_tb.sv
module shq_credit_qm_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arr_valid = 1'b0, dep_req = 1'b0, crd_valid = 1'b0;
  logic [2:0] arr_fg = '0, crd_fg = '0;
  logic [1:0] arr_port = '0, dep_port = '0;
  logic [7:0] arr_cell = '0;
  logic       arr_ready, rsp_valid, rsp_hit;
  logic [7:0] rsp_cell;
  logic [2:0] rsp_fg;
  logic [8:0] used_slots;
  logic [3:0] ready_nonempty;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shq_credit_qm u_dut (
    .clk(clk), .rst_n(rst_n),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_fg(arr_fg),
    .arr_port(arr_port), .arr_cell(arr_cell),
    .dep_req(dep_req), .dep_port(dep_port),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cell(rsp_cell), .rsp_fg(rsp_fg),
    .crd_valid(crd_valid), .crd_fg(crd_fg),
    .used_slots(used_slots), .ready_nonempty(ready_nonempty)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic       av; logic [2:0] afg; logic [1:0] ao; logic [7:0] ac;
    logic       dv; logic [1:0] dp;
    logic       cv; logic [2:0] cf;
    logic       eh; logic [7:0] ec; logic [8:0] eu;
  } vec_t;

  // rq, arrival(v,fg,out,cell), departure(v,out), credit(v,fg), expect(hit,cell,used)
  localparam vec_t VT [23] = '{
    '{4, 0,0,0,0,   0,0, 1,1, 0,0,0},   // R4 credit to empty group: count up
    '{2, 1,1,0,10,  0,0, 0,0, 0,0,1},   // R2 arrival spends it -> ready
    '{3, 1,1,0,11,  0,0, 0,0, 0,0,2},   // R3 no credit -> waiting
    '{6, 0,0,0,0,   1,0, 0,0, 1,10,1},  // R6 hit
    '{7, 0,0,0,0,   1,0, 0,0, 0,0,1},   // R7 miss, parked cell untouched
    '{4, 0,0,0,0,   0,0, 1,1, 0,0,1},   // R4 credit releases cell 11
    '{6, 0,0,0,0,   1,0, 0,0, 1,11,0},
    '{3, 1,2,1,20,  0,0, 0,0, 0,0,1},
    '{3, 1,2,1,21,  0,0, 0,0, 0,0,2},
    '{10,1,2,1,22,  0,0, 1,2, 0,0,3},   // R10 credit moves 20, 22 parks
    '{9, 0,0,0,0,   1,1, 1,2, 1,20,2},  // R9 order kept
    '{9, 0,0,0,0,   1,1, 1,2, 1,21,1},
    '{9, 0,0,0,0,   1,1, 0,0, 1,22,0},
    '{10,1,3,2,30,  0,0, 1,3, 0,0,1},   // R10 credit then arrival -> ready
    '{11,1,3,2,31,  1,2, 0,0, 1,30,1},  // R11 arrival+departure one cycle
    '{7, 0,0,0,0,   1,2, 0,0, 0,0,1},
    '{10,0,0,0,0,   1,2, 1,3, 0,0,1},   // R10 departure sees old state
    '{6, 0,0,0,0,   1,2, 0,0, 1,31,0},
    '{4, 0,0,0,0,   0,0, 1,4, 0,0,0},
    '{2, 1,4,3,40,  0,0, 0,0, 0,0,1},
    '{11,0,0,0,0,   1,3, 1,4, 1,40,0},
    '{2, 1,4,3,41,  0,0, 0,0, 0,0,1},
    '{6, 0,0,0,0,   1,3, 0,0, 1,41,0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic drive(input bit av, input int afg, input int ao, input int ac,
                       input bit dv, input int dp, input bit cv, input int cf);
    arr_valid = av; arr_fg = 3'(afg); arr_port = 2'(ao); arr_cell = 8'(ac);
    dep_req = dv; dep_port = 2'(dp);
    crd_valid = cv; crd_fg = 3'(cf);
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 used", used_slots, 0);
    check("R1 ready_nonempty", ready_nonempty, 0);
    check("R1 arr_ready", arr_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);

    foreach (VT[k]) begin
      drive(VT[k].av, VT[k].afg, VT[k].ao, VT[k].ac, VT[k].dv, VT[k].dp, VT[k].cv, VT[k].cf);
      check($sformatf("R%0d vec%0d rsp_valid", VT[k].rq, k), rsp_valid, VT[k].dv);
      if (VT[k].dv) check($sformatf("R%0d vec%0d hit", VT[k].rq, k), rsp_hit, VT[k].eh);
      if (VT[k].eh) check($sformatf("R%0d vec%0d cell", VT[k].rq, k), rsp_cell, VT[k].ec);
      check($sformatf("R%0d vec%0d used", VT[k].rq, k), used_slots, VT[k].eu);
    end

    // R5 saturation: 9 credits keep only 7
    for (int i = 0; i < 9; i++) drive(0, 0, 0, 0, 0, 0, 1, 5);
    for (int i = 0; i < 9; i++) drive(1, 5, 0, 100 + i, 0, 0, 0, 0);
    check("R5 used", used_slots, 9);
    for (int i = 0; i < 7; i++) begin
      drive(0, 0, 0, 0, 1, 0, 0, 0);
      check("R5 hit", rsp_hit, 1);
      check("R6 cell order", rsp_cell, 100 + i);
      check("R6 fg", rsp_fg, 5);
    end
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    check("R5 eighth misses", rsp_hit, 0);
    for (int i = 0; i < 2; i++) begin
      drive(0, 0, 0, 0, 0, 0, 1, 5);
      drive(0, 0, 0, 0, 1, 0, 0, 0);
      check("R9 released cell", rsp_cell, 107 + i);
    end
    check("R5 drained", used_slots, 0);

    // R8 fill the pool (all park in group 6)
    for (int i = 0; i < 256; i++) drive(1, 6, 1, i, 0, 0, 0, 0);
    check("R8 full count", used_slots, 256);
    check("R8 arr_ready low", arr_ready, 0);
    drive(1, 6, 1, 7, 0, 0, 0, 0);
    check("R8 refused arrival", used_slots, 256);
    drive(0, 0, 0, 0, 0, 0, 1, 6);
    drive(0, 0, 0, 0, 1, 1, 0, 0);
    check("R8 first out", rsp_cell, 0);
    check("R8 reopen used", used_slots, 255);
    check("R8 reopen ready", arr_ready, 1);
    // R11 credit and departure every cycle
    drive(0, 0, 0, 0, 0, 0, 1, 6);
    for (int j = 2; j < 256; j++) begin
      drive(0, 0, 0, 0, 1, 1, 1, 6);
      check("R11 streaming hit", rsp_hit, 1);
      check("R11 streaming cell", rsp_cell, j - 1);
    end
    drive(0, 0, 0, 0, 1, 1, 0, 0);
    check("R11 last cell", rsp_cell, 255);
    check("R11 drained", used_slots, 0);

    // R1 reset in mid-run
    drive(0, 0, 0, 0, 0, 0, 1, 7);
    drive(1, 7, 0, 5, 0, 0, 0, 0);
    check("R2 ready flag", ready_nonempty, 1);
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    check("R1 mid reset used", used_slots, 0);
    check("R1 mid reset flags", ready_nonempty, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    check("R1 mid reset miss", rsp_hit, 0);
    drive(1, 7, 0, 6, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    check("R1 credit cleared", rsp_hit, 0);
    idle();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule